// File: doc/BRIEF.md
# Coarse-Fine Hit Timestamper

This block gives the rising edge of an asynchronous hit signal a digital timestamp. A coarse counter runs freely on the system clock. A fast clock, an integer number of times faster and phase-locked to the system clock, is supplied as four copies spaced a quarter of its period apart. Each copy samples the hit. The four samples from one fast cycle form a thermometer code. The position of the first high sample gives a phase code. A counter that restarts at every system clock edge supplies the index of the fast cycle within the coarse period. The result is a quarter of the fast period. With a 40 MHz system clock and a 400 MHz fast clock, that is a 625 ps bin and 40 bins per coarse period.

The timestamp has three fields: the coarse count, the fast-cycle index and the phase code. Its linear value is coarse·RATIO·4 + index·4 + phase, counted in bins from the first system clock edge after the synchronous start input is released. The coarse field wraps without limit, so the measurement range is bounded only by how the wrap is handled downstream. The fast ratio is a parameter, so a slower build works the same way: a 200 MHz fast clock against a 40 MHz system clock gives 1.25 ns bins. Only the first rising edge is stamped. Another edge is accepted only after the hit has been low across a whole fast-cycle window. The phase clocks come from outside the block, and any phase-skew correction is also done outside.

Top module: `tdc_multiphase`

## Requirements
- R1: While `rst` is high the coarse count is held at 0. At the first `clk_sys` rising edge with `rst` low (time t0) the count starts at 0. It then increments by one per system period and wraps modulo 2^COARSE_W.
- R2: `stamp_phase` is the index k (0..3) of the first phase sample in the fast cycle that saw the hit high. Phase k samples a quarter fast period after phase k-1, and phase 0 is aligned with the fast cycle start.
- R3: `stamp_fast` is always below FAST_RATIO. It is 0 for the fast cycle that begins at a `clk_sys` rising edge, and it rises by one for each following fast cycle.
- R4: For a hit rising at time h, the linear value coarse·FAST_RATIO·4 + fast·4 + phase equals ceil((h − t0)/LSB) modulo 2^COARSE_W·FAST_RATIO·4, within ±1. LSB is a quarter of the fast clock period.
- R5: Each accepted edge gives exactly one `stamp_valid` pulse, one fast cycle wide, in the `clk_ph[0]` domain. The timestamp fields are valid while `stamp_valid` is high.
- R6: After a capture, no new capture is made until one full fast-cycle window has sampled the hit low on all four phases. A hit held high, or a low dip shorter than a fast period, produces no further pulse.
- R7: `stamp_valid` stays low while `rst` is high. A hit that is already high when `rst` is released is not stamped until it has gone low and risen again.
- R8: `stamp_valid` rises within four fast clock periods of the hit's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock that drives the coarse counter |
| clk_ph | input | 4 | Fast clock phases; bit k lags bit 0 by k quarter periods |
| rst | input | 1 | Synchronous start; high clears and holds the block |
| hit | input | 1 | Asynchronous hit signal whose rising edges are stamped |
| stamp_valid | output | 1 | One-cycle pulse in the clk_ph[0] domain marking a new timestamp |
| stamp_coarse | output | COARSE_W | Coarse count of the stamped edge |
| stamp_fast | output | $clog2(FAST_RATIO) | Fast-cycle index within the coarse period |
| stamp_phase | output | 2 | Quarter-period phase code |

## Verification
Hits are swept over every bin of the coarse period and across several wraps of a narrowed coarse counter, with sub-bin offsets in different places. A fast-cycle index that slips against the system edge shows up on the next stamp as an error of whole groups of four bins. The bench flags it against the arithmetic expectation, and an assertion flags it at the first system edge that arrives at the wrong count. A phase sampler that is mis-wired or has a mis-ordered synchronizer shows up as wrong phase codes within the first four hits of the sweep. A fault in the arming state shows up as a missing or doubled valid pulse during the glitch, long-hold and restart tests, no more than a dozen fast cycles after the edge concerned.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int NPH  = 4;
    localparam int PH_W = $clog2(NPH);

    // Lowest index whose sample saw the hit high (0 when none)
    function automatic logic [PH_W-1:0] first_high(input logic [NPH-1:0] w);
        logic [PH_W-1:0] r;
        r = '0;
        for (int k = NPH - 1; k >= 0; k--) begin
            if (w[k]) r = PH_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
    parameter int COARSE_W = 16
) (
    input  logic                clk_sys,
    input  logic                rst,
    output logic [COARSE_W-1:0] coarse_o,
    output logic                tgl_o,
    output logic                run_o
);

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic                tgl;
        logic                run;
    } crs_t;

    crs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.run    = 1'b1;
            st_d.coarse = st_q.run ? COARSE_W'(st_q.coarse + 1'b1) : '0;
            st_d.tgl    = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk_sys) begin
        st_q <= st_d;
    end

    assign coarse_o = st_q.coarse;
    assign tgl_o    = st_q.tgl;
    assign run_o    = st_q.run;

    // R1
    coarse_step_chk: assert property (@(posedge clk_sys) disable iff (rst)
        $past(st_q.run) |-> st_q.coarse == COARSE_W'($past(st_q.coarse) + 1'b1));

endmodule

// File: rtl/tdc_fine.sv
module tdc_fine
    import tdc_pkg::*;
(
    input  logic [NPH-1:0] clk_ph,
    input  logic           hit,
    output logic [NPH-1:0] win_o
);

    logic [NPH-1:0] samp;

    // One sampling flop per phase, each in its own clock domain
    for (genvar k = 0; k < NPH; k++) begin : g_ph
        logic s_q;
        always_ff @(posedge clk_ph[k]) begin
            s_q <= hit;
        end
        assign samp[k] = s_q;
    end

    typedef struct packed {
        logic [NPH-1:0] m1;
        logic [NPH-1:0] m2;
    } sync_t;

    sync_t sy_d, sy_q;

    // Two-stage retiming into the phase-0 domain; one edge collects
    // samples taken at window start + k quarter periods
    always_comb begin
        sy_d.m1 = samp;
        sy_d.m2 = sy_q.m1;
    end

    always_ff @(posedge clk_ph[0]) begin
        sy_q <= sy_d;
    end

    assign win_o = sy_q.m2;

endmodule

// File: rtl/tdc_stamp.sv
module tdc_stamp
    import tdc_pkg::*;
#(
    parameter int COARSE_W   = 16,
    parameter int FAST_RATIO = 10
) (
    input  logic                          clk_fast,
    input  logic                          rst,
    input  logic                          run_i,
    input  logic                          tgl_i,
    input  logic [COARSE_W-1:0]           coarse_i,
    input  logic [NPH-1:0]                win_i,
    output logic                          valid_o,
    output logic [COARSE_W-1:0]           coarse_o,
    output logic [$clog2(FAST_RATIO)-1:0] fast_o,
    output logic [PH_W-1:0]               phase_o
);

    localparam int IDX_W = $clog2(FAST_RATIO);

    typedef struct packed {
        logic [IDX_W-1:0]    cnt;
        logic                tgl_s;
        logic [COARSE_W-1:0] c1;
        logic [IDX_W-1:0]    i1;
        logic [COARSE_W-1:0] c2;
        logic [IDX_W-1:0]    i2;
        logic                armed;
        logic                valid;
        logic [COARSE_W-1:0] oc;
        logic [IDX_W-1:0]    oi;
        logic [PH_W-1:0]     op;
    } stp_t;

    stp_t st_d, st_q;
    logic             sys_edge;
    logic [IDX_W-1:0] idx;

    // A changed toggle means a system edge began the cycle that just ended
    assign sys_edge = (tgl_i != st_q.tgl_s);
    assign idx      = sys_edge ? '0 : st_q.cnt;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.tgl_s = tgl_i;
        st_d.cnt   = IDX_W'(idx + 1'b1);
        // Tags follow the window through the two synchronizer stages
        st_d.c1    = coarse_i;
        st_d.i1    = idx;
        st_d.c2    = st_q.c1;
        st_d.i2    = st_q.i1;
        if (st_q.armed && (|win_i)) begin
            st_d.valid = 1'b1;
            st_d.armed = 1'b0;
            st_d.oc    = st_q.c2;
            st_d.oi    = st_q.i2;
            st_d.op    = first_high(win_i);
        end else if (~|win_i) begin
            st_d.armed = 1'b1;
        end
        if (!run_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk_fast) begin
        st_q <= st_d;
    end

    assign valid_o  = st_q.valid;
    assign coarse_o = st_q.oc;
    assign fast_o   = st_q.oi;
    assign phase_o  = st_q.op;

    // R3
    sys_align_chk: assert property (@(posedge clk_fast) disable iff (rst)
        (run_i && $past(run_i) && sys_edge) |-> $past(idx) == IDX_W'(FAST_RATIO - 1));

    // R3
    idx_range_chk: assert property (@(posedge clk_fast) disable iff (rst)
        st_q.valid |-> st_q.oi < IDX_W'(FAST_RATIO));

    // R5
    single_pulse_chk: assert property (@(posedge clk_fast) disable iff (rst)
        st_q.valid |=> !st_q.valid);

endmodule

// File: rtl/tdc_multiphase.sv
module tdc_multiphase
    import tdc_pkg::*;
#(
    parameter int COARSE_W   = 16,
    parameter int FAST_RATIO = 10
) (
    input  logic                          clk_sys,
    input  logic [NPH-1:0]                clk_ph,
    input  logic                          rst,
    input  logic                          hit,
    output logic                          stamp_valid,
    output logic [COARSE_W-1:0]           stamp_coarse,
    output logic [$clog2(FAST_RATIO)-1:0] stamp_fast,
    output logic [PH_W-1:0]               stamp_phase
);

    logic [COARSE_W-1:0] coarse;
    logic                tgl;
    logic                run;
    logic [NPH-1:0]      win;

    tdc_coarse #(.COARSE_W(COARSE_W)) u_coarse (
        .clk_sys  (clk_sys),
        .rst      (rst),
        .coarse_o (coarse),
        .tgl_o    (tgl),
        .run_o    (run)
    );

    tdc_fine u_fine (
        .clk_ph (clk_ph),
        .hit    (hit),
        .win_o  (win)
    );

    tdc_stamp #(.COARSE_W(COARSE_W), .FAST_RATIO(FAST_RATIO)) u_stamp (
        .clk_fast (clk_ph[0]),
        .rst      (rst),
        .run_i    (run),
        .tgl_i    (tgl),
        .coarse_i (coarse),
        .win_i    (win),
        .valid_o  (stamp_valid),
        .coarse_o (stamp_coarse),
        .fast_o   (stamp_fast),
        .phase_o  (stamp_phase)
    );

endmodule

// File: tb/tdc_multiphase_tb.sv
`timescale 1ps/1ps
module tdc_multiphase_tb;

    localparam int CW   = 6;
    localparam int R    = 10;
    localparam int TSYS = 8000;
    localparam int TF   = TSYS / R;
    localparam int LSB  = TF / 4;
    localparam int SPAN = (1 << CW) * R * 4;

    logic clk_sys = 1'b0;
    logic ph0 = 1'b0, ph1 = 1'b0, ph2 = 1'b0, ph3 = 1'b0;
    logic [3:0] clk_ph;
    logic rst = 1'b1;
    logic hit = 1'b0;
    logic stamp_valid;
    logic [CW-1:0] stamp_coarse;
    logic [$clog2(R)-1:0] stamp_fast;
    logic [1:0] stamp_phase;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    longint t0 = 0;

    assign clk_ph = {ph3, ph2, ph1, ph0};

    tdc_multiphase #(.COARSE_W(CW), .FAST_RATIO(R)) u_dut (
        .clk_sys      (clk_sys),
        .clk_ph       (clk_ph),
        .rst          (rst),
        .hit          (hit),
        .stamp_valid  (stamp_valid),
        .stamp_coarse (stamp_coarse),
        .stamp_fast   (stamp_fast),
        .stamp_phase  (stamp_phase)
    );

    // 125 MHz system clock; rising edges at 4000 + 8000*m ps
    initial forever #(TSYS/2) clk_sys = ~clk_sys;
    initial begin #(TF);           forever begin ph0 = ~ph0; #(TF/2); end end
    initial begin #(TF + LSB);     forever begin ph1 = ~ph1; #(TF/2); end end
    initial begin #(TF + 2*LSB);   forever begin ph2 = ~ph2; #(TF/2); end end
    initial begin #(TF + 3*LSB);   forever begin ph3 = ~ph3; #(TF/2); end end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one rising edge so the first sample to see it is bin tgt
    task automatic pulse(input int tgt, input int off, input bit glitch, input int hold);
        longint h;
        longint lin;
        longint diff;
        int nval;
        int first;
        logic [CW-1:0] c_cap;
        logic [$clog2(R)-1:0] f_cap;
        logic [1:0] p_cap;
        h = t0 + longint'(tgt - 1) * LSB + off;
        nval = 0;
        first = -1;
        c_cap = '0; f_cap = '0; p_cap = '0;
        if (h > $time) #(h - $time);
        hit = 1'b1;
        if (glitch) begin
            #300 hit = 1'b0;
            #300 hit = 1'b1;
        end
        for (int n = 1; n <= hold; n++) begin
            @(negedge clk_ph[0]);
            if (stamp_valid) begin
                nval++;
                if (first < 0) begin
                    first = n;
                    c_cap = stamp_coarse;
                    f_cap = stamp_fast;
                    p_cap = stamp_phase;
                end
            end
        end
        hit = 1'b0;
        if (glitch || hold > 12)
            chk(nval == 1, "R6 one stamp per edge", nval, 1);
        else
            chk(nval == 1, "R5 one valid pulse", nval, 1);
        if (nval >= 1) begin
            lin  = longint'(c_cap) * R * 4 + longint'(f_cap) * 4 + p_cap;
            diff = (lin - (tgt % SPAN) + SPAN) % SPAN;
            chk(diff == 0 || diff == 1 || diff == SPAN - 1, "R4 time", lin, tgt % SPAN);
            chk(p_cap == 2'(tgt % 4), "R2 phase", p_cap, tgt % 4);
            chk(f_cap < R && f_cap == ($clog2(R))'((tgt / 4) % R), "R3 fast index", f_cap, (tgt / 4) % R);
            chk(c_cap == CW'((tgt / (4 * R)) % (1 << CW)), "R1 coarse", c_cap, (tgt / (4 * R)) % (1 << CW));
            chk(first <= 4, "R8 latency", first, 4);
        end
        #(4 * TF);
    endtask

    function automatic int next_bin();
        return int'(($time - t0) / LSB) + 20;
    endfunction

    initial begin
        #(64'd400_000_000);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int nv;
        repeat (3) @(negedge clk_sys);
        chk(stamp_valid == 1'b0, "R7 reset valid low", stamp_valid, 0);
        rst = 1'b0;
        @(posedge clk_sys);
        t0 = $time;

        // Sweep: step 87 bins walks every bin of the period and wraps coarse
        for (int i = 0; i < 160; i++) begin
            pulse(40 + i * 87, 30 + 70 * (i % 3), 1'b0, 12);
        end

        // R6: short low dip does not re-arm
        pulse(next_bin(), 60, 1'b1, 12);
        // R6: long hold gives a single stamp
        pulse(next_bin(), 120, 1'b0, 40);

        // R7: restart with hit already high
        @(negedge clk_sys);
        rst = 1'b1;
        hit = 1'b1;
        repeat (3) begin
            @(negedge clk_sys);
            chk(stamp_valid == 1'b0, "R7 valid low in reset", stamp_valid, 0);
        end
        rst = 1'b0;
        @(posedge clk_sys);
        t0 = $time;
        nv = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk_ph[0]);
            if (stamp_valid) nv++;
        end
        chk(nv == 0, "R7 held hit not stamped", nv, 0);
        hit = 1'b0;
        #(4 * TF);
        // R1: coarse restarts from zero after the new start
        pulse(next_bin(), 90, 1'b0, 12);
        pulse(next_bin() + 41, 10, 1'b0, 12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule